// File: doc/BRIEF.md
# Serializer with boundary bits

This block turns a parallel data word into a serial stream on a single-bit line. A slot enable marks the serial bit times, and twelve slots make one word period, which is one parallel clock period. At the start of each period the block captures the parallel input. It then sends the ten data bits, least significant first. Two boundary bits follow, so a receiver can find the word edges again after the link is interrupted.

The block also controls power for the link. A run input brings the link up and down. Bringing it up starts a lock interval, during which the line is not driven. A synchronisation interval of filler words follows. Only after both intervals does the block report that it is ready and start capturing real data. Taking the run input low sends a power-down indication to the far end and then releases the line.

The far end can ask for a restart by holding the link high. When the block sees this while it is driving the link, it releases the line for a back-off interval. It then runs the lock and synchronisation sequence again. All intervals are counted in word periods and set by parameters.

Top module: `ser_link_tx`

## Requirements
- R1: While `ready` is high, `pdata` is captured once per word period, at the slot-enable cycle that opens the period, and `take` pulses for one cycle right after that capture. With `slot_en` high every cycle, two `take` pulses are exactly 12 cycles apart.
- R2: A word is sent in 12 slots. Slot k (k = 0..9) carries data bit k, slot 10 carries the first boundary bit and slot 11 carries the second. Each slot's bit appears on `sd_o` in the cycle after the slot-enable edge that starts it.
- R3: The first boundary bit is the inverse of data bit 9, and the second boundary bit is the inverse of the first. Every word therefore holds at least two level changes.
- R4: When `link_on` rises, `sd_oe` stays low for LOCK_WORDS word periods. It then goes high on the clock edge that ends the last lock period.
- R5: After `sd_oe` rises, the block sends filler words for SYNC_WORDS word periods: all-zero data, so the second-to-last slot is 1 and every other slot is 0. `ready` rises on the edge that ends the last filler period, and only words captured after that are data.
- R6: When `link_on` is sampled low while the line is driven, `ready` falls on that edge. `sd_o` is then driven 0 for exactly one full word period as a power-down indication, and `sd_oe` falls at its end.
- R7: When `far_hold` is sampled high while `link_on` and `ready` are high, `sd_oe` and `ready` fall on that edge. After BACKOFF_WORDS + LOCK_WORDS word periods `sd_oe` rises again, and SYNC_WORDS periods later data transfer resumes.
- R8: `far_hold` has no effect while `link_on` is low. It neither shortens the power-down indication nor drives the line.
- R9: The serial state advances only in cycles where `slot_en` is high. When `slot_en` is high every other cycle, words keep the format of R2 and `take` pulses are 24 cycles apart.
- R10: While `rst` is high and just after it is released with `link_on` low, `sd_oe`, `sd_o`, `ready` and `take` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Serial slot enable, 12 per word period |
| link_on | input | 1 | High to run the link, low for power-down |
| far_hold | input | 1 | High when the far end holds the link high |
| pdata | input | DATA_W | Parallel word to send |
| sd_o | output | 1 | Serial data |
| sd_oe | output | 1 | Serial output drive enable; low means high impedance |
| ready | output | 1 | Lock and synchronisation done, words are data |
| take | output | 1 | One-cycle pulse after each data word capture |

## Verification
The scoreboard words cover all zeros, all ones, the two alternating patterns, a lone high bit 9 and its complement. These tell a reversed bit order from a correct one, and a boundary bit taken from the wrong data bit from one taken from bit 9. A walking one then covers every single bit position. The same words are sent again with the slot enable high every other cycle, to show that gaps stretch the word without changing its format. The power-up, power-down and back-off sequences are timed to the exact edge. This separates an interval that is one word period too short or too long, and a power-down indication that a far-end hold cuts short.

// File: rtl/ser_link_pkg.sv
`timescale 1ns/1ps
package ser_link_pkg;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_LOCK = 3'd1,
    PS_SYNC = 3'd2,
    PS_RUN  = 3'd3,
    PS_NOTE = 3'd4,
    PS_BACK = 3'd5
  } pwr_state_t;

  // Boundary pair {second, first}: first = ~last data bit, second = ~first.
  function automatic logic [1:0] oh_pair(input logic last_bit);
    return {last_bit, ~last_bit};
  endfunction

endpackage

// File: rtl/ser_slot_timer.sv
`timescale 1ns/1ps
module ser_slot_timer #(
  parameter int SLOTS = 12,
  parameter int CW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          slot_en,
  output logic [CW-1:0] slot_cnt,
  output logic          load,
  output logic          wtick
);

  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  // load: the slot that opens a word period; wtick: the slot that closes it
  assign load  = slot_en && (slot_cnt == '0);
  assign wtick = slot_en && (slot_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      slot_cnt <= '0;
    end else if (slot_en) begin
      slot_cnt <= (slot_cnt == LAST) ? '0 : slot_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ser_power_seq.sv
`timescale 1ns/1ps
module ser_power_seq
  import ser_link_pkg::*;
#(
  parameter int LOCK_WORDS    = 2048,
  parameter int SYNC_WORDS    = 9216,
  parameter int BACKOFF_WORDS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic link_on,
  input  logic far_hold,
  input  logic wtick,
  output logic hold,
  output logic tx_act,
  output logic data_ok,
  output logic drive
);

  localparam int MAX_AB = (LOCK_WORDS > SYNC_WORDS) ? LOCK_WORDS : SYNC_WORDS;
  localparam int MAXW   = (MAX_AB > BACKOFF_WORDS) ? MAX_AB : BACKOFF_WORDS;
  localparam int CNT_W  = $clog2(MAXW + 1);

  localparam logic [CNT_W-1:0] LOCK_END = CNT_W'(LOCK_WORDS - 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_WORDS - 1);
  localparam logic [CNT_W-1:0] BACK_END = CNT_W'(BACKOFF_WORDS - 1);

  pwr_state_t       st, nxt;
  logic [CNT_W-1:0] wcnt;

  always_comb begin
    nxt = st;
    unique case (st)
      PS_OFF:  if (link_on) nxt = PS_LOCK;
      PS_LOCK: begin
        if (!link_on)                        nxt = PS_OFF;
        else if (wtick && wcnt == LOCK_END)  nxt = PS_SYNC;
      end
      PS_SYNC: begin
        if (!link_on)                        nxt = PS_NOTE;
        else if (far_hold)                   nxt = PS_BACK;
        else if (wtick && wcnt == SYNC_END)  nxt = PS_RUN;
      end
      PS_RUN: begin
        if (!link_on)                        nxt = PS_NOTE;
        else if (far_hold)                   nxt = PS_BACK;
      end
      PS_NOTE: if (wtick) nxt = PS_OFF;
      PS_BACK: begin
        if (!link_on)                        nxt = PS_OFF;
        else if (wtick && wcnt == BACK_END)  nxt = PS_LOCK;
      end
      default: nxt = PS_OFF;
    endcase
  end

  // Every state change restarts the word period at slot 0
  assign hold    = (nxt != st) || (st == PS_OFF);
  assign tx_act  = (st == PS_SYNC) || (st == PS_RUN);
  assign data_ok = (st == PS_RUN);
  assign drive   = tx_act || (st == PS_NOTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PS_OFF;
      wcnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)  wcnt <= '0;
      else if (wtick) wcnt <= wcnt + 1'b1;
    end
  end

endmodule

// File: rtl/ser_frame_shifter.sv
`timescale 1ns/1ps
module ser_frame_shifter
  import ser_link_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int FW     = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              slot_en,
  input  logic              tx_run,
  input  logic              data_ok,
  input  logic [DATA_W-1:0] din,
  output logic              sd_q,
  output logic              take
);

  logic [DATA_W-1:0] src;
  logic [FW-1:0]     frame, sh;

  // Filler words carry zero data; real words carry the captured input
  assign src   = data_ok ? din : '0;
  assign frame = {oh_pair(src[DATA_W-1]), src};

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q <= 1'b0;
      sh   <= '0;
      take <= 1'b0;
    end else begin
      take <= load && tx_run && data_ok;
      if (!tx_run) begin
        sd_q <= 1'b0;
        sh   <= '0;
      end else if (load) begin
        sd_q <= frame[0];
        sh   <= frame >> 1;
      end else if (slot_en) begin
        sd_q <= sh[0];
        sh   <= sh >> 1;
      end
    end
  end

endmodule

// File: rtl/ser_link_tx.sv
`timescale 1ns/1ps
module ser_link_tx #(
  parameter int DATA_W        = 10,
  parameter int LOCK_WORDS    = 2048,
  parameter int SYNC_WORDS    = 9216,
  parameter int BACKOFF_WORDS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_en,
  input  logic              link_on,
  input  logic              far_hold,
  input  logic [DATA_W-1:0] pdata,
  output logic              sd_o,
  output logic              sd_oe,
  output logic              ready,
  output logic              take
);

  localparam int SLOTS  = DATA_W + 2;
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] slot_cnt;
  logic load, wtick, hold, tx_act, data_ok, drive, tx_run;

  ser_slot_timer #(.SLOTS(SLOTS), .CW(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(hold), .slot_en(slot_en),
    .slot_cnt(slot_cnt), .load(load), .wtick(wtick)
  );

  ser_power_seq #(
    .LOCK_WORDS(LOCK_WORDS), .SYNC_WORDS(SYNC_WORDS), .BACKOFF_WORDS(BACKOFF_WORDS)
  ) u_seq (
    .clk(clk), .rst(rst), .link_on(link_on), .far_hold(far_hold), .wtick(wtick),
    .hold(hold), .tx_act(tx_act), .data_ok(data_ok), .drive(drive)
  );

  assign tx_run = tx_act && !hold;

  ser_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .slot_en(slot_en), .tx_run(tx_run),
    .data_ok(data_ok), .din(pdata), .sd_q(sd_o), .take(take)
  );

  assign sd_oe = drive;
  assign ready = data_ok;

endmodule

// File: rtl/ser_link_tx_chk.sv
`timescale 1ns/1ps
module ser_link_tx_chk #(
  parameter int SLOTS = 12,
  parameter int CW    = $clog2(SLOTS)
) (
  input logic          clk,
  input logic          rst,
  input logic          link_on,
  input logic          far_hold,
  input logic          slot_en,
  input logic          sd_o,
  input logic          sd_oe,
  input logic          ready,
  input logic          take,
  input logic [CW-1:0] slot_cnt,
  input logic          tx_act
);

  logic b9_q, b9_ok, oh1_q, oh_ok;

  // Record the line during the last data slot and during the first boundary slot
  always_ff @(posedge clk) begin
    if (rst || !tx_act) begin
      b9_q <= 1'b0; b9_ok <= 1'b0; oh1_q <= 1'b0; oh_ok <= 1'b0;
    end else if (slot_en) begin
      if (slot_cnt == CW'(SLOTS - 2)) begin
        b9_q <= sd_o; b9_ok <= 1'b1;
      end
      if (slot_cnt == CW'(SLOTS - 1)) begin
        oh1_q <= sd_o; oh_ok <= b9_ok;
      end
    end
  end

  assert_take_once_R1: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  assert_oh1_inv_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_en && tx_act && b9_ok && slot_cnt == CW'(SLOTS - 1)) |-> (sd_o != b9_q));

  assert_oh2_inv_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_en && tx_act && oh_ok && slot_cnt == '0) |-> (sd_o != oh1_q));

  assert_ready_driven_R5: assert property (@(posedge clk) disable iff (rst)
    ready |-> sd_oe);

  assert_pdn_ready_R6: assert property (@(posedge clk) disable iff (rst)
    !link_on |=> !ready);

  assert_pdn_stays_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!link_on && !sd_oe) |=> !sd_oe);

  assert_backoff_R7: assert property (@(posedge clk) disable iff (rst)
    (far_hold && link_on && ready) |=> (!sd_oe && !ready));

endmodule

bind ser_link_tx ser_link_tx_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .link_on(link_on), .far_hold(far_hold), .slot_en(slot_en),
  .sd_o(sd_o), .sd_oe(sd_oe), .ready(ready), .take(take),
  .slot_cnt(slot_cnt), .tx_act(tx_act)
);

// File: tb/sim_ser_link_tx.sv
`timescale 1ns/1ps
module sim_ser_link_tx;

  localparam int DW = 10;
  localparam int LW = 3;
  localparam int SW = 4;
  localparam int BW = 2;
  localparam int SL = DW + 2;

  logic clk = 1'b0, rst = 1'b1, slot_en = 1'b1, link_on = 1'b0, far_hold = 1'b0;
  logic [DW-1:0] pdata = '0;
  logic sd_o, sd_oe, ready, take;

  ser_link_tx #(.DATA_W(DW), .LOCK_WORDS(LW), .SYNC_WORDS(SW), .BACKOFF_WORDS(BW)) u0 (
    .clk(clk), .rst(rst), .slot_en(slot_en), .link_on(link_on), .far_hold(far_hold),
    .pdata(pdata), .sd_o(sd_o), .sd_oe(sd_oe), .ready(ready), .take(take)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit gap_mode = 1'b0, done = 1'b0, en_q = 1'b0;
  logic [SL-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [SL-1:0] mk_frame(input logic [DW-1:0] w);
    logic oh1;
    oh1 = ~w[DW-1];
    return {~oh1, oh1, w};
  endfunction

  // Slot enable: every cycle, or every other cycle in gap mode
  initial forever begin
    @(negedge clk);
    slot_en = gap_mode ? ~slot_en : 1'b1;
  end

  always @(posedge clk) en_q <= slot_en;

  // Monitor: rebuild each data word from the line and compare with the scoreboard
  initial begin : monitor
    logic [SL-1:0] got;
    logic [SL-1:0] exp;
    int idx;
    bit coll;
    int ntr;
    coll = 1'b0; idx = 0; got = '0;
    forever begin
      @(negedge clk);
      if (coll && (!sd_oe || !ready)) coll = 1'b0;
      if (take) begin
        got = '0; got[0] = sd_o; idx = 1; coll = 1'b1;
      end else if (coll && en_q) begin
        got[idx] = sd_o;
        idx++;
        if (idx == SL) begin
          coll = 1'b0;
          if (exp_q.size() > 0) begin
            exp = exp_q.pop_front();
            chk(got == exp, "R2", "frame bits", int'(got), int'(exp));
            ntr = 0;
            for (int i = 1; i < SL; i++) if (got[i] != got[i-1]) ntr++;
            chk(ntr >= 2 && got[SL-2] == ~got[DW-1] && got[SL-1] == ~got[SL-2],
                "R3", "boundary bits", int'(got[SL-1:SL-2]), int'(exp[SL-1:SL-2]));
          end
        end
      end
    end
  end

  task automatic send_word(input logic [DW-1:0] w);
    pdata = w;
    do @(negedge clk); while (!take);
    exp_q.push_back(mk_frame(w));
  endtask

  task automatic drain();
    repeat (2 * SL + 4) @(negedge clk);
  endtask

  // Raises link_on (or pulses far_hold) and times the driven and ready edges
  task automatic time_bringup(input bit from_backoff, input int exp_oe,
                              input int exp_rdy, input string req);
    int koe, krdy, idle_bad;
    koe = -1; krdy = -1; idle_bad = 0;
    if (from_backoff) far_hold = 1'b1; else link_on = 1'b1;
    for (int k = 0; k < exp_rdy + 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      far_hold = 1'b0;
      if (sd_oe && koe < 0) koe = k;
      if (ready && krdy < 0) krdy = k;
      if (koe >= 0 && k > koe && k <= koe + SL)
        if (sd_o !== ((k - koe - 1) == SL - 2)) idle_bad++;
    end
    chk(koe == exp_oe, req, "edge where line becomes driven", koe, exp_oe);
    chk(idle_bad == 0, "R5", "filler word pattern mismatches", idle_bad, 0);
    chk(krdy == exp_rdy, "R5", "edge where ready rises", krdy, exp_rdy);
  endtask

  task automatic take_gap(input int exp, input string req);
    int n;
    do @(negedge clk); while (!take);
    n = 0;
    do begin @(negedge clk); n++; end while (!take && n < 100);
    chk(n == exp, req, "cycles between captures", n, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int bad;
    repeat (3) @(negedge clk);
    chk(sd_oe == 0 && ready == 0 && take == 0 && sd_o == 0, "R10", "outputs in reset",
        int'({sd_oe, ready, take, sd_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sd_oe == 0 && ready == 0 && take == 0 && sd_o == 0, "R10", "outputs after reset",
        int'({sd_oe, ready, take, sd_o}), 0);

    // R8: far-end hold with the link off drives nothing
    far_hold = 1'b1;
    bad = 0;
    repeat (30) begin @(negedge clk); if (sd_oe || sd_o) bad++; end
    far_hold = 1'b0;
    chk(bad == 0, "R8", "driven cycles with link off", bad, 0);

    // R4/R5: first power-up
    time_bringup(1'b0, SL * LW, SL * (LW + SW), "R4");

    // R1/R2/R3: data patterns
    send_word(10'h000); send_word(10'h3FF); send_word(10'h155); send_word(10'h2AA);
    send_word(10'h200); send_word(10'h1FF);
    for (int b = 0; b < DW; b++) send_word(DW'(1) << b);
    drain();
    take_gap(SL, "R1");

    // R9: slot enable every other cycle
    gap_mode = 1'b1;
    repeat (4) @(negedge clk);
    send_word(10'h0F3); send_word(10'h30C); send_word(10'h2B4);
    drain();
    take_gap(2 * SL, "R9");
    gap_mode = 1'b0;
    drain();

    // R6/R8: power-down indication, far_hold must not cut it short
    link_on = 1'b0;
    far_hold = 1'b1;
    bad = 0;
    for (int k = 0; k < SL; k++) begin
      @(posedge clk); @(negedge clk);
      if (!sd_oe || ready || sd_o) bad++;
    end
    chk(bad == 0, "R6", "bad cycles in power-down word", bad, 0);
    @(posedge clk); @(negedge clk);
    chk(sd_oe == 0, "R6", "line driven after power-down word", int'(sd_oe), 0);
    far_hold = 1'b0;
    repeat (5) @(negedge clk);

    // Second power-up, then the far-end back-off and restart
    time_bringup(1'b0, SL * LW, SL * (LW + SW), "R4");
    send_word(10'h123); send_word(10'h2DC);
    drain();
    time_bringup(1'b1, SL * (BW + LW), SL * (BW + LW + SW), "R7");
    send_word(10'h381); send_word(10'h07E);
    drain();
    chk(exp_q.size() == 0, "R7", "words left unsent", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule